// File: doc/BRIEF.md
# Streaming Insertion Sorter with Selectable Eviction

The block holds a sliding window of up to `N` integer samples, always kept in sorted order. Each sample taken from the input stream is placed at its ordered slot by a chain of identical slot cells. Each cell works out its own next value from its two neighbours, the position of the removed entry and the position of the new entry. While the window holds fewer samples than the active size, samples are only stored. Once the window is full, every new sample pushes one stored element out to the output stream. A compile-time parameter picks which element leaves: the oldest one, the one at a fixed slot, or the one at a slot given on an input port.

A sample marked as the last of its stream is inserted like any other sample. After that the block drains the whole window, in sorted-view order, and flags the final element it sends. The full sorted window is always visible as a parallel bus, together with empty and full flags. The active window size and the sort direction can be changed at run time, but only while the block is empty. Stored values that compare equal leave the window in arrival order, because a new sample goes behind any equal entry.

Top module: `lis_sorter`

## Requirements
- R1: The sorted view holds the stored samples in positions 0 to count-1. With direction 1 they run ascending from position 0, and with direction 0 they run descending. Every position at or above the count reads zero.
- R2: While the count is below the active size, an accepted sample is stored and nothing is emitted. `full_o` rises when the count reaches the active size.
- R3: Each sample accepted while full puts exactly one evicted element on `out_data`. It is valid in the cycle after acceptance, and the count stays unchanged.
- R4: With the oldest-first scheme, the evicted element is the stored sample that arrived earliest.
- R5: With a positional scheme, the evicted element is the one at the chosen sorted-view position (0 is the first position). The position is `FIX_POS` or `evict_pos`, and any position at or above the active size is treated as size-1.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value.
- R7: When a sample with `in_last` high is accepted, it is first handled like any other sample. The remaining stored elements then stream out from sorted-view position 0 upward. `out_last` is high only on the final one. `in_ready` stays low until the window is empty, and `empty_o` then reads 1.
- R8: A `cfg_wr` pulse sets the active size from `cfg_size` and the direction from `cfg_dir` (1 ascending, 0 descending). It takes effect only when the block is empty, not flushing, and accepting no sample in that cycle. Otherwise the pulse is ignored. A size outside 1..N leaves the size unchanged, but the direction is still applied.
- R9: After reset: `empty_o`=1, `full_o`=0, `out_valid`=0, `in_ready`=1, the sorted view is all zero, the active size is N and the direction is `DIR_INIT`.
- R10: Samples compare as two's-complement values when `SIGNED_DATA`=1 and as unsigned values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW | Input sample |
| in_last | input | 1 | Marks the final sample of the stream; starts a drain |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream can take the element |
| out_data | output | DW | Evicted or drained element |
| out_last | output | 1 | Final element of a drain |
| sorted_o | output | N*DW | Sorted window; position k at bits [k*DW +: DW] |
| empty_o | output | 1 | Window holds no sample |
| full_o | output | 1 | Count equals the active size |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_size | input | $clog2(N+1) | Requested active size |
| cfg_dir | input | 1 | Requested direction, 1 ascending |
| evict_pos | input | $clog2(N+1) | Eviction position for the run-time positional scheme |

## Verification
The bench builds two instances. The first uses the oldest-first scheme with N=5 and unsigned 8-bit data, so a size that is not a power of two is covered. It also exercises run-time resizing down to 3, descending order, refused reconfiguration, back-pressure and draining. The second uses the run-time positional scheme with N=4 and signed data. It reaches negative ordering, eviction at inner positions, clamping of an out-of-range position, and a drain that starts before the window is full.

// File: rtl/lis_pkg.sv
package lis_pkg;
  typedef enum logic [1:0] {
    EVICT_OLDEST = 2'd0,
    EVICT_FIXED  = 2'd1,
    EVICT_PORT   = 2'd2
  } evict_e;
endpackage

// File: rtl/lis_rst_sync.sv
module lis_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/lis_cell.sv
// One slot of the cascade. Stage c: close the gap left by a removal.
// Stage n: open a gap at the insertion position and drop the new sample in.
module lis_cell #(
  parameter int DW          = 8,
  parameter int CW          = 3,
  parameter int IDX         = 0,
  parameter bit SIGNED_DATA = 1'b0
) (
  input  logic [DW-1:0] d_self,
  input  logic [CW-1:0] a_self,
  input  logic [DW-1:0] d_next,
  input  logic [CW-1:0] a_next,
  input  logic [DW-1:0] c_prev,
  input  logic [CW-1:0] ca_prev,
  input  logic          rm,
  input  logic [CW-1:0] rm_idx,
  input  logic          ins,
  input  logic [CW-1:0] ins_pos,
  input  logic [CW-1:0] kept,
  input  logic [DW-1:0] new_data,
  input  logic          asc,
  output logic [DW-1:0] c_val,
  output logic [CW-1:0] c_age,
  output logic          ahead,
  output logic [DW-1:0] n_val,
  output logic [CW-1:0] n_age
);
  localparam logic [CW-1:0] MY_IDX = CW'(IDX);

  logic shift_in;
  logic le_new;
  logic ge_new;

  assign shift_in = rm && (MY_IDX >= rm_idx);
  assign c_val    = shift_in ? d_next : d_self;
  assign c_age    = shift_in ? a_next : a_self;

  generate
    if (SIGNED_DATA) begin : g_signed
      assign le_new = $signed(c_val) <= $signed(new_data);
      assign ge_new = $signed(c_val) >= $signed(new_data);
    end else begin : g_unsigned
      assign le_new = c_val <= new_data;
      assign ge_new = c_val >= new_data;
    end
  endgenerate

  // equal entries stay ahead of the newcomer
  assign ahead = (MY_IDX < kept) && (asc ? le_new : ge_new);

  always_comb begin
    n_val = c_val;
    n_age = c_age;
    if (ins) begin
      if (MY_IDX < ins_pos) begin
        n_val = c_val;
        n_age = c_age + 1'b1;
      end else if (MY_IDX == ins_pos) begin
        n_val = new_data;
        n_age = '0;
      end else begin
        n_val = c_prev;
        n_age = ca_prev + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lis_evict.sv
module lis_evict #(
  parameter int             N       = 5,
  parameter int             CW      = 3,
  parameter lis_pkg::evict_e SCHEME = lis_pkg::EVICT_OLDEST,
  parameter int             FIX_POS = 0
) (
  input  logic [N*CW-1:0] ages,
  input  logic [CW-1:0]   count,
  input  logic [CW-1:0]   size,
  input  logic [CW-1:0]   sel_pos,
  output logic [CW-1:0]   idx
);
  localparam logic [CW-1:0] FIX_P = CW'(FIX_POS);

  generate
    if (SCHEME == lis_pkg::EVICT_OLDEST) begin : g_oldest
      always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
          if ((CW'(i) < count) && (ages[i*CW +: CW] == size - 1'b1)) idx = CW'(i);
        end
      end
    end else if (SCHEME == lis_pkg::EVICT_FIXED) begin : g_fixed
      assign idx = (FIX_P >= size) ? size - 1'b1 : FIX_P;
    end else begin : g_port
      assign idx = (sel_pos >= size) ? size - 1'b1 : sel_pos;
    end
  endgenerate
endmodule

// File: rtl/lis_sorter.sv
module lis_sorter #(
  parameter int              DW          = 8,
  parameter int              N           = 5,
  parameter bit              SIGNED_DATA = 1'b0,
  parameter bit              DIR_INIT    = 1'b1,
  parameter lis_pkg::evict_e SCHEME      = lis_pkg::EVICT_OLDEST,
  parameter int              FIX_POS     = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DW-1:0]           in_data,
  input  logic                    in_last,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_data,
  output logic                    out_last,
  output logic [N*DW-1:0]         sorted_o,
  output logic                    empty_o,
  output logic                    full_o,
  input  logic                    cfg_wr,
  input  logic [$clog2(N+1)-1:0]  cfg_size,
  input  logic                    cfg_dir,
  input  logic [$clog2(N+1)-1:0]  evict_pos
);
  localparam int CW = $clog2(N+1);
  localparam logic [CW-1:0] NMAX = CW'(N);

  logic rst_i;

  logic [DW-1:0] mem_q [N];
  logic [DW-1:0] mem_d [N];
  logic [CW-1:0] age_q [N];
  logic [CW-1:0] age_d [N];
  logic [DW-1:0] cv    [N];
  logic [CW-1:0] ca    [N];
  logic [N-1:0]  ahead;
  logic [N*CW-1:0] age_flat;

  logic [CW-1:0] cnt_q, cnt_d, sz_q, sz_d;
  logic          asc_q, asc_d, flush_q, flush_d;
  logic          ov_q, ov_d, ol_q, ol_d;
  logic [DW-1:0] od_q, od_d;

  logic          out_free, acc, pop, rm, arr_en, cfg_ok, evict_on_acc;
  logic [CW-1:0] ev_idx, rm_idx, kept, ins_pos;

  lis_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  // handshake and control decode
  assign empty_o      = (cnt_q == '0);
  assign full_o       = (cnt_q == sz_q);
  assign out_free     = !ov_q || out_ready;
  assign in_ready     = !flush_q && out_free;
  assign acc          = in_valid && in_ready;
  assign evict_on_acc = acc && full_o;
  assign pop          = flush_q && out_free && !empty_o;
  assign rm           = evict_on_acc || pop;
  assign rm_idx       = pop ? '0 : ev_idx;
  assign kept         = rm ? cnt_q - 1'b1 : cnt_q;
  assign arr_en       = acc || pop;
  assign cfg_ok       = cfg_wr && empty_o && !flush_q && !acc;

  generate
    for (genvar i = 0; i < N; i++) begin : g_age
      assign age_flat[i*CW +: CW] = age_q[i];
    end
  endgenerate

  lis_evict #(.N(N), .CW(CW), .SCHEME(SCHEME), .FIX_POS(FIX_POS)) u_evict (
    .ages(age_flat), .count(cnt_q), .size(sz_q), .sel_pos(evict_pos), .idx(ev_idx)
  );

  // slot cascade
  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      logic [DW-1:0] nxt_d, prv_c;
      logic [CW-1:0] nxt_a, prv_a;
      if (i == N-1) begin : g_top
        assign nxt_d = '0;
        assign nxt_a = '0;
      end else begin : g_mid
        assign nxt_d = mem_q[i+1];
        assign nxt_a = age_q[i+1];
      end
      if (i == 0) begin : g_bot
        assign prv_c = '0;
        assign prv_a = '0;
      end else begin : g_link
        assign prv_c = cv[i-1];
        assign prv_a = ca[i-1];
      end
      lis_cell #(.DW(DW), .CW(CW), .IDX(i), .SIGNED_DATA(SIGNED_DATA)) u_cell (
        .d_self(mem_q[i]), .a_self(age_q[i]), .d_next(nxt_d), .a_next(nxt_a),
        .c_prev(prv_c), .ca_prev(prv_a), .rm(rm), .rm_idx(rm_idx),
        .ins(acc), .ins_pos(ins_pos), .kept(kept), .new_data(in_data),
        .asc(asc_q), .c_val(cv[i]), .c_age(ca[i]), .ahead(ahead[i]),
        .n_val(mem_d[i]), .n_age(age_d[i])
      );
      assign sorted_o[i*DW +: DW] = mem_q[i];
    end
  endgenerate

  always_comb begin
    ins_pos = '0;
    for (int i = 0; i < N; i++) ins_pos = ins_pos + CW'(ahead[i]);
  end

  // next state
  always_comb begin
    cnt_d   = cnt_q;
    sz_d    = sz_q;
    asc_d   = asc_q;
    flush_d = flush_q;
    ov_d    = ov_q && !out_ready;
    ol_d    = ol_q && !out_ready;
    od_d    = od_q;
    if (acc && !full_o) cnt_d = cnt_q + 1'b1;
    else if (pop)       cnt_d = cnt_q - 1'b1;
    if (rm) begin
      ov_d = 1'b1;
      od_d = mem_q[rm_idx];
      ol_d = pop && (cnt_q == CW'(1));
    end
    if (acc && in_last)                flush_d = 1'b1;
    else if (pop && cnt_q == CW'(1))   flush_d = 1'b0;
    if (cfg_ok) begin
      asc_d = cfg_dir;
      if (cfg_size != '0 && cfg_size <= NMAX) sz_d = cfg_size;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int i = 0; i < N; i++) begin
        mem_q[i] <= '0;
        age_q[i] <= '0;
      end
      cnt_q   <= '0;
      sz_q    <= NMAX;
      asc_q   <= DIR_INIT;
      flush_q <= 1'b0;
      ov_q    <= 1'b0;
      ol_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      if (arr_en) begin
        for (int i = 0; i < N; i++) begin
          mem_q[i] <= mem_d[i];
          age_q[i] <= age_d[i];
        end
      end
      cnt_q   <= cnt_d;
      sz_q    <= sz_d;
      asc_q   <= asc_d;
      flush_q <= flush_d;
      ov_q    <= ov_d;
      ol_q    <= ol_d;
      if (rm) od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;

  // checks
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_i)
    cnt_q <= sz_q);
  p_fill_silent_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_ready && !full_o) |=> !out_valid);
  p_full_emits_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_ready && full_o) |=> (out_valid && full_o));
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_ready) |-> !in_ready);
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_flush_closed_r7: assert property (@(posedge clk) disable iff (!rst_i)
    flush_q |-> !in_ready);
  p_cfg_refused_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_wr && !empty_o) |=> ($stable(sz_q) && $stable(asc_q)));

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      p_zero_above_r1: assert property (@(posedge clk) disable iff (!rst_i)
        (CW'(i) >= cnt_q) |-> (mem_q[i] == '0));
      if (i < N-1) begin : g_pair
        if (SIGNED_DATA) begin : g_s
          p_order_r1: assert property (@(posedge clk) disable iff (!rst_i)
            (CW'(i+1) < cnt_q) |-> (asc_q ? ($signed(mem_q[i]) <= $signed(mem_q[i+1]))
                                          : ($signed(mem_q[i]) >= $signed(mem_q[i+1]))));
        end else begin : g_u
          p_order_r1: assert property (@(posedge clk) disable iff (!rst_i)
            (CW'(i+1) < cnt_q) |-> (asc_q ? (mem_q[i] <= mem_q[i+1])
                                          : (mem_q[i] >= mem_q[i+1])));
        end
      end
    end
  endgenerate
endmodule

// File: tb/lis_sorter_test.sv
`timescale 1ns/1ps
module lis_sorter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // instance A: oldest-first, N=5, unsigned
  logic       a_in_valid = 0, a_in_last = 0, a_out_ready = 1, a_cfg_wr = 0, a_cfg_dir = 0;
  logic [7:0] a_in_data = 0;
  logic [2:0] a_cfg_size = 0;
  logic       a_in_ready, a_out_valid, a_out_last, a_empty, a_full;
  logic [7:0] a_out_data;
  logic [39:0] a_sorted;

  lis_sorter #(.DW(8), .N(5), .SIGNED_DATA(1'b0), .DIR_INIT(1'b1),
               .SCHEME(lis_pkg::EVICT_OLDEST), .FIX_POS(0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(a_in_valid), .in_ready(a_in_ready),
    .in_data(a_in_data), .in_last(a_in_last), .out_valid(a_out_valid),
    .out_ready(a_out_ready), .out_data(a_out_data), .out_last(a_out_last),
    .sorted_o(a_sorted), .empty_o(a_empty), .full_o(a_full), .cfg_wr(a_cfg_wr),
    .cfg_size(a_cfg_size), .cfg_dir(a_cfg_dir), .evict_pos(3'd0));

  // instance B: position from port, N=4, signed
  logic       b_in_valid = 0, b_in_last = 0;
  logic [7:0] b_in_data = 0;
  logic [2:0] b_pos = 0;
  logic       b_in_ready, b_out_valid, b_out_last, b_empty, b_full;
  logic [7:0] b_out_data;
  logic [31:0] b_sorted;

  lis_sorter #(.DW(8), .N(4), .SIGNED_DATA(1'b1), .DIR_INIT(1'b1),
               .SCHEME(lis_pkg::EVICT_PORT), .FIX_POS(0)) uut_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid), .in_ready(b_in_ready),
    .in_data(b_in_data), .in_last(b_in_last), .out_valid(b_out_valid),
    .out_ready(1'b1), .out_data(b_out_data), .out_last(b_out_last),
    .sorted_o(b_sorted), .empty_o(b_empty), .full_o(b_full), .cfg_wr(1'b0),
    .cfg_size(3'd0), .cfg_dir(1'b0), .evict_pos(b_pos));

  int a_log [64];
  bit a_lst [64];
  int a_n = 0;
  int b_log [64];
  bit b_lst [64];
  int b_n = 0;

  always @(posedge clk) begin
    if (a_out_valid && a_out_ready && a_n < 64) begin
      a_log[a_n] = a_out_data; a_lst[a_n] = a_out_last; a_n++;
    end
    if (b_out_valid && b_n < 64) begin
      b_log[b_n] = $signed(b_out_data); b_lst[b_n] = b_out_last; b_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_a(input int v, input bit last);
    @(negedge clk);
    a_in_valid = 1; a_in_data = 8'(v); a_in_last = last;
    while (!a_in_ready) @(negedge clk);
    @(negedge clk);
    a_in_valid = 0; a_in_last = 0;
  endtask

  task automatic push_b(input int v, input bit last);
    @(negedge clk);
    b_in_valid = 1; b_in_data = 8'(v); b_in_last = last;
    while (!b_in_ready) @(negedge clk);
    @(negedge clk);
    b_in_valid = 0; b_in_last = 0;
  endtask

  task automatic cfg_a(input int sz, input bit dir);
    @(negedge clk);
    a_cfg_wr = 1; a_cfg_size = 3'(sz); a_cfg_dir = dir;
    @(negedge clk);
    a_cfg_wr = 0;
  endtask

  task automatic view_a(input string req, input int e0, input int e1, input int e2,
                        input int e3, input int e4);
    int exp [5];
    exp = '{e0, e1, e2, e3, e4};
    for (int k = 0; k < 5; k++) chk(req, $sformatf("A view[%0d]", k), a_sorted[k*8 +: 8], exp[k]);
  endtask

  task automatic view_b(input string req, input int e0, input int e1, input int e2, input int e3);
    int exp [4];
    exp = '{e0, e1, e2, e3};
    for (int k = 0; k < 4; k++)
      chk(req, $sformatf("B view[%0d]", k), $signed(b_sorted[k*8 +: 8]), exp[k]);
  endtask

  task automatic out_a(input string req, input int k, input int v, input bit last);
    chk(req, $sformatf("A out#%0d", k), a_log[k], v);
    chk(req, $sformatf("A last#%0d", k), a_lst[k], last);
  endtask

  task automatic out_b(input string req, input int k, input int v, input bit last);
    chk(req, $sformatf("B out#%0d", k), b_log[k], v);
    chk(req, $sformatf("B last#%0d", k), b_lst[k], last);
  endtask

  task automatic t_reset;
    chk("R9", "A empty", a_empty, 1);
    chk("R9", "A full", a_full, 0);
    chk("R9", "A out_valid", a_out_valid, 0);
    chk("R9", "A in_ready", a_in_ready, 1);
    view_a("R9", 0, 0, 0, 0, 0);
    chk("R9", "B empty", b_empty, 1);
  endtask

  task automatic t_fill;
    push_a(30, 0); push_a(10, 0); push_a(20, 0); push_a(10, 0);
    idle(2);
    chk("R2", "A full at 4", a_full, 0);
    push_a(40, 0);
    idle(2);
    chk("R2", "A outputs while filling", a_n, 0);
    chk("R2", "A full at 5", a_full, 1);
    view_a("R1", 10, 10, 20, 30, 40);
  endtask

  task automatic t_oldest;
    push_a(25, 0); push_a(5, 0); push_a(50, 0);
    idle(2);
    chk("R3", "A one out per sample", a_n, 3);
    out_a("R4", 0, 30, 0);
    out_a("R4", 1, 10, 0);
    out_a("R4", 2, 20, 0);
    view_a("R1", 5, 10, 25, 40, 50);
    chk("R3", "A still full", a_full, 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    a_out_ready = 0;
    push_a(60, 0);
    chk("R6", "A in_ready stalled", a_in_ready, 0);
    chk("R6", "A out_valid", a_out_valid, 1);
    chk("R6", "A out_data", a_out_data, 10);
    a_in_valid = 1; a_in_data = 8'd99;
    idle(2);
    a_in_valid = 0;
    chk("R6", "A out_data held", a_out_data, 10);
    view_a("R6", 5, 25, 40, 50, 60);
    a_out_ready = 1;
    idle(2);
    chk("R6", "A count after release", a_n, 4);
    out_a("R4", 3, 10, 0);
  endtask

  task automatic t_flush;
    push_a(35, 1);
    chk("R7", "A in_ready while draining", a_in_ready, 0);
    idle(8);
    out_a("R7", 4, 40, 0);
    out_a("R7", 5, 5, 0);
    out_a("R7", 6, 25, 0);
    out_a("R7", 7, 35, 0);
    out_a("R7", 8, 50, 0);
    out_a("R7", 9, 60, 1);
    chk("R7", "A empty after drain", a_empty, 1);
    chk("R7", "A in_ready after drain", a_in_ready, 1);
  endtask

  task automatic t_resize;
    cfg_a(3, 0);
    push_a(7, 0); push_a(9, 0); push_a(8, 0);
    idle(2);
    chk("R8", "A full at size 3", a_full, 1);
    view_a("R8", 9, 8, 7, 0, 0);
    push_a(1, 0);
    cfg_a(5, 1);
    push_a(4, 0);
    idle(2);
    out_a("R8", 10, 7, 0);
    out_a("R8", 11, 9, 0);
    chk("R8", "A size kept", a_full, 1);
    view_a("R8", 8, 4, 1, 0, 0);
    push_a(2, 1);
    idle(6);
    out_a("R7", 12, 8, 0);
    out_a("R7", 13, 4, 0);
    out_a("R7", 14, 2, 0);
    out_a("R7", 15, 1, 1);
    cfg_a(0, 1);
    push_a(6, 0); push_a(2, 0); push_a(4, 0);
    idle(2);
    chk("R8", "A bad size ignored", a_full, 1);
    view_a("R8", 2, 4, 6, 0, 0);
  endtask

  task automatic t_port_evict;
    push_b(5, 0); push_b(-3, 0); push_b(0, 0);
    idle(2);
    chk("R2", "B not full", b_full, 0);
    push_b(-8, 0);
    idle(2);
    view_b("R10", -8, -3, 0, 5);
    b_pos = 3'd2;
    push_b(2, 0);
    b_pos = 3'd7;
    push_b(-1, 0);
    idle(2);
    out_b("R5", 0, 0, 0);
    out_b("R5", 1, 5, 0);
    view_b("R5", -8, -3, -1, 2);
    b_pos = 3'd0;
    push_b(9, 1);
    idle(7);
    out_b("R5", 2, -8, 0);
    out_b("R7", 3, -3, 0);
    out_b("R7", 4, -1, 0);
    out_b("R7", 5, 2, 0);
    out_b("R7", 6, 9, 1);
    push_b(1, 0); push_b(3, 1);
    idle(5);
    out_b("R7", 7, 1, 0);
    out_b("R7", 8, 3, 1);
    chk("R7", "B count", b_n, 9);
    chk("R7", "B empty", b_empty, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(4);
    t_reset();
    t_fill();
    t_oldest();
    t_backpressure();
    t_flush();
    t_resize();
    t_port_evict();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule